// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control sequencer of a 10-bit successive-approximation analog-to-digital converter. It runs from a clock whose period is the basic time unit, so every interval it produces is an exact number of clock cycles. A 4-bit timing word selects two periods. The conversion step period is one of three fixed lengths. The sampling period is a power-of-two multiple of the step period. A start pulse launches a conversion that always has the same shape. First comes a sample window of two sampling periods, with the sample-enable output high. Then come fourteen step periods. The first ten decide one result bit each, most significant first. The bit's trial code is driven to an external DAC, and the comparator answer read back decides whether that bit is kept. The last four steps only let internal levels settle. A fixed four-cycle transfer interval then follows, at whose close the result register is loaded and done pulses.

The timing word is captured when a start is accepted, and it has no further effect until the conversion finishes. A start that arrives while a conversion runs is dropped. A start that asks for the reserved step-period code launches nothing and raises a one-cycle error flag instead.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, busy, done, sample_en and cfg_err are low, and result and dac_code are zero.
- R2: The step period tCC is set by timing_cfg[3:2]: 00 gives 24 cycles, 11 gives 48 cycles and 10 gives 96 cycles. Code 01 is reserved.
- R3: The sampling period tSC is tCC multiplied by 1, 2, 4 or 8 for timing_cfg[1:0] = 00, 01, 10 or 11.
- R4: sample_en is high for exactly 2·tSC cycles, starting in the cycle after the clock edge that accepts start, and is low at all other times.
- R5: busy is high for exactly N = 14·tCC + 2·tSC + 4 cycles after the accepting edge. done is a one-cycle pulse in the first cycle after busy falls.
- R6: The result is found by successive approximation, MSB first: each trial bit is set and is kept only when cmp_ge is high. With cmp_ge = (input ≥ dac_code), the result equals the input clamped to 1023.
- R7: dac_code is 512 in the first step cycle. During the four trailing settle steps it holds the final result code.
- R8: A start pulse while busy is high is ignored. The running conversion keeps its timing and its result, and cfg_err stays low.
- R9: A start while idle with timing_cfg[3:2] = 01 starts no conversion, and cfg_err is high for exactly the next cycle.
- R10: timing_cfg is captured on the accepting edge. Later changes to it do not alter the running conversion.
- R11: result changes only in the cycle in which done is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one period per time unit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a conversion |
| timing_cfg | input | 4 | [3:2] step period code, [1:0] sampling multiple code |
| cmp_ge | input | 1 | Comparator: analog input at or above DAC level |
| sample_en | output | 1 | High during the sample window |
| dac_code | output | 10 | Trial code for the external DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when result is written |
| cfg_err | output | 1 | One-cycle pulse on a rejected reserved-code start |
| result | output | 10 | Last conversion result |

## Verification
The hardest situation to reach from the ports is a second start, or a change of the timing word, landing in the middle of a running conversion. A wrong design would restart or retime the sequence there, so the damage only shows as a shifted done edge several thousand cycles later. The bench reaches it by injecting a start and a fresh timing word at chosen offsets within the sample window and the step phase. It then counts busy, sample-enable and done cycles against the interval computed from the captured word. The clamped input and the two extreme codes exercise the boundaries of the bit decision.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic [1:0] step_sel;
        logic [1:0] samp_sel;
    } timing_cfg_t;

    localparam logic [1:0] STEP_SEL_RESERVED = 2'b01;

    function automatic int unsigned step_period(input logic [1:0] sel);
        case (sel)
            2'b10:   return 96;
            2'b11:   return 48;
            default: return 24;
        endcase
    endfunction

    function automatic int unsigned sample_window(input timing_cfg_t cfg);
        return 2 * (step_period(cfg.step_sel) << cfg.samp_sel);
    endfunction

    function automatic logic is_reserved(input timing_cfg_t cfg);
        return cfg.step_sel == STEP_SEL_RESERVED;
    endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == '0);

    assert_timer_countdown_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_timer_load_R5: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> (cnt_q == $past(load_val) - CNT_W'(1)));

endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             decide,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] code
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] keep_bit;

    assign keep_bit = cmp_ge ? mask_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init) begin
            code_q <= TOP_BIT;
            mask_q <= TOP_BIT;
        end else if (decide) begin
            code_q <= (code_q & ~mask_q) | keep_bit | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code = code_q;

    assert_trial_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));

    assert_decide_has_bit_R6: assert property (@(posedge clk) disable iff (rst)
        decide |-> (mask_q != '0));

    assert_init_msb_R7: assert property (@(posedge clk) disable iff (rst)
        init |=> (code_q == TOP_BIT));

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sar_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int PAD_STEPS = 4,
    parameter int XFER_CYC  = 4,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       timing_cfg,
    input  logic             cmp_ge,
    output logic             sample_en,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic             cfg_err,
    output logic [RES_W-1:0] result
);

    localparam int TOTAL_STEPS = RES_W + PAD_STEPS;
    localparam int STEP_W      = $clog2(TOTAL_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_STEPS - 1);
    localparam logic [STEP_W-1:0] DECIDE_LIM = STEP_W'(RES_W);

    seq_state_e       state_q, state_d;
    timing_cfg_t      cfg_in, cfg_q;
    logic [STEP_W-1:0] step_q;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic             idle_start, accept, reject;
    logic             sar_init, sar_decide;
    logic [RES_W-1:0] sar_code;

    assign cfg_in     = timing_cfg_t'(timing_cfg);
    assign idle_start = start && (state_q == ST_IDLE);
    assign accept     = idle_start && !is_reserved(cfg_in);
    assign reject     = idle_start && is_reserved(cfg_in);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SAMPLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(sample_window(cfg_in));
                end
            end
            ST_SAMPLE: begin
                if (tmr_exp) begin
                    state_d  = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(step_period(cfg_q.step_sel));
                end
            end
            ST_CONV: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (step_q == LAST_STEP) begin
                        state_d = ST_XFER;
                        tmr_val = CNT_W'(XFER_CYC);
                    end else begin
                        tmr_val = CNT_W'(step_period(cfg_q.step_sel));
                    end
                end
            end
            ST_XFER: begin
                if (tmr_exp) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sar_init   = (state_q == ST_SAMPLE) && tmr_exp;
    assign sar_decide = (state_q == ST_CONV) && tmr_exp && (step_q < DECIDE_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            step_q  <= '0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
            result  <= '0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_XFER) && tmr_exp;
            cfg_err <= reject;
            if (accept) begin
                cfg_q <= cfg_in;
            end
            if (sar_init) begin
                step_q <= '0;
            end else if ((state_q == ST_CONV) && tmr_exp && (step_q != LAST_STEP)) begin
                step_q <= step_q + STEP_W'(1);
            end
            if ((state_q == ST_XFER) && tmr_exp) begin
                result <= sar_code;
            end
        end
    end

    sar_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    sar_seq_approx #(.RES_W(RES_W)) approx_i (
        .clk    (clk),
        .rst    (rst),
        .init   (sar_init),
        .decide (sar_decide),
        .cmp_ge (cmp_ge),
        .code   (sar_code)
    );

    assign dac_code  = sar_code;
    assign sample_en = (state_q == ST_SAMPLE);
    assign busy      = (state_q != ST_IDLE);

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_sample_inside_busy_R4: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy);

    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    assert_err_no_run_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!busy && !done));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !cfg_err);

    assert_result_only_on_done_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_step_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV) |-> (step_q <= LAST_STEP));

endmodule

// File: tb/sar_conv_sequencer_tb_top.sv
module sar_conv_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] cfg_drv;
    logic       cmp_ge;
    logic       sample_en, busy, done, cfg_err;
    logic [9:0] dac_code, result;
    int         vin_r;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #2 clk = ~clk;

    assign cmp_ge = (vin_r >= int'(dac_code));

    sar_conv_sequencer dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .timing_cfg (cfg_drv),
        .cmp_ge     (cmp_ge),
        .sample_en  (sample_en),
        .dac_code   (dac_code),
        .busy       (busy),
        .done       (done),
        .cfg_err    (cfg_err),
        .result     (result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_tcc(input logic [1:0] sel);
        case (sel)
            2'b00:   return 24;
            2'b10:   return 96;
            2'b11:   return 48;
            default: return 0;
        endcase
    endfunction

    // R1: reset state
    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !done && !sample_en && !cfg_err, "R1 control outputs idle",
            int'({busy, done, sample_en, cfg_err}), 0);
        chk(result == 10'd0 && dac_code == 10'd0, "R1 data outputs zero",
            int'(result) + int'(dac_code), 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10 R11: one full conversion with optional disturbances
    task automatic run_conv(input logic [3:0] cfg, input int vin, input bit poke_start,
                            input bit poke_cfg, input string req);
        int tcc, tsc, s, n, exp_res, busy_cnt, samp_cnt, bad_samp, bad_res, bad_done, err_seen;
        logic [9:0] old_res;
        tcc      = exp_tcc(cfg[3:2]);
        tsc      = tcc << cfg[1:0];
        s        = 2 * tsc;
        n        = 14 * tcc + s + 4;
        exp_res  = (vin > 1023) ? 1023 : vin;
        busy_cnt = 0; samp_cnt = 0; bad_samp = 0; bad_res = 0; bad_done = 0; err_seen = 0;
        @(negedge clk);
        vin_r   = vin;
        cfg_drv = cfg;
        start   = 1'b1;
        old_res = result;
        for (int idx = 1; idx <= n + 1; idx++) begin
            @(negedge clk);
            if (idx == 1) start = 1'b0;
            if (poke_cfg && idx == 3) cfg_drv = {~cfg[3], 1'b1, ~cfg[1:0]};
            if (poke_start && (idx == 5 || idx == s + 7)) begin
                start   = 1'b1;
                cfg_drv = 4'b0011;
            end
            if (poke_start && (idx == 6 || idx == s + 8)) begin
                start   = 1'b0;
                cfg_drv = 4'b0100;
            end
            if (busy) busy_cnt++;
            if (sample_en) begin
                samp_cnt++;
                if (idx > s) bad_samp++;
            end else if (idx <= s) begin
                bad_samp++;
            end
            if (cfg_err) err_seen++;
            if (idx <= n) begin
                if (result != old_res) bad_res++;
                if (done) bad_done++;
            end
            if (idx == s + 1)
                chk(dac_code == 10'd512, {req, " R7 first trial"}, int'(dac_code), 512);
            if (idx == s + 10 * tcc + 1)
                chk(int'(dac_code) == exp_res, {req, " R7 settle code"}, int'(dac_code), exp_res);
            if (idx == n + 1) begin
                chk(done == 1'b1, {req, " R5 done at N"}, int'(done), 1);
                chk(int'(result) == exp_res, {req, " R6 result"}, int'(result), exp_res);
            end
        end
        start   = 1'b0;
        cfg_drv = 4'b0000;
        chk(busy_cnt == n, {req, " R5 busy cycles"}, busy_cnt, n);
        chk(samp_cnt == s && bad_samp == 0, {req, " R4 sample window"}, samp_cnt, s);
        chk(bad_res == 0 && bad_done == 0, {req, " R11 result held"}, bad_res + bad_done, 0);
        if (poke_start)
            chk(err_seen == 0, {req, " R8 no error on busy start"}, err_seen, 0);
        @(negedge clk);
        chk(!done && !busy, {req, " R5 done one cycle"}, int'({done, busy}), 0);
    endtask

    // R9: reserved step code rejected
    task automatic test_reserved();
        logic [9:0] old_res;
        old_res = result;
        @(negedge clk);
        cfg_drv = 4'b0110;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err && !busy && !sample_en, "R9 error pulse no run",
            int'({cfg_err, busy, sample_en}), 4);
        @(negedge clk);
        chk(!cfg_err && !busy, "R9 error one cycle", int'({cfg_err, busy}), 0);
        repeat (30) @(negedge clk);
        chk(!done && !busy && result == old_res, "R9 no conversion ran",
            int'(result), int'(old_res));
        cfg_drv = 4'b0000;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst     = 1'b1;
        start   = 1'b0;
        cfg_drv = 4'b0000;
        vin_r   = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        run_conv(4'b0000, 300,  1'b0, 1'b0, "R2 R3 fastest");
        run_conv(4'b1000, 1023, 1'b0, 1'b0, "R2 step 96");
        run_conv(4'b1101, 0,    1'b0, 1'b0, "R2 R3 step 48 x2");
        run_conv(4'b0010, 513,  1'b0, 1'b0, "R3 x4");
        run_conv(4'b0011, 682,  1'b0, 1'b0, "R3 x8");
        run_conv(4'b1111, 1,    1'b1, 1'b0, "R8 busy start");
        run_conv(4'b1001, 511,  1'b0, 1'b1, "R10 cfg change");
        test_reserved();
        run_conv(4'b0000, 2000, 1'b0, 1'b0, "R6 clamp");
        summary();
        $finish;
    end

endmodule